// File: doc/BRIEF.md
# Privilege Ring Guard

This unit keeps the current privilege ring of a small processor model and rules on every decoded operation handed to it. Ring 0 carries full privilege and ring 3 the least. Each operation arrives as a class code, with an interrupt vector for software interrupts, and one cycle later the unit reports whether it is permitted or faulted. It also reports the ring now in force, the handler address chosen by a gate, and the ring saved or restored by that operation.

The ring changes in only two ways. A software interrupt looks up a vectored gate, a table of 256 entries that each hold a handler address and a target ring, and adopts that gate's ring. An interrupt return restores the ring that was current when the matching interrupt was taken. Interrupts nest, so the saved rings live on a small last-in, first-out stack inside the unit. The gate table is filled through a write port. A 2-bit I/O threshold register limits which rings may touch device ports.

Top module: `ring_guard`

## Requirements
- R1: After reset the current ring is 0, no result is flagged valid, the I/O threshold is 0, the return stack is empty and every gate entry holds address 0 and ring 0.
- R2: Op classes 1 (interrupt enable), 2 (interrupt disable) and 3 (page-directory base load) are permitted only in ring 0. In rings 1 to 3 they fault, and the ring does not change.
- R3: Op class 4 (port I/O) is permitted when the current ring is numerically at or below the I/O threshold, and faults otherwise. The threshold is written with `io_lim_we`/`io_lim`.
- R4: Op class 5 (software interrupt) with a free stack slot is permitted. It sets the ring to the target ring of gate `op_vec`, reports that gate's handler address and reports the prior ring as the saved ring.
- R5: Op class 6 (interrupt return) with a non-empty stack is permitted. It restores the most recently saved ring and reports it as the saved ring, so nested interrupts unwind in reverse order.
- R6: The stack holds 8 levels. A software interrupt when 8 levels are held faults, and it changes neither the ring nor the stack.
- R7: An interrupt return with an empty stack faults and leaves the ring unchanged.
- R8: Op class 0 and the unused code 7 are always permitted and change nothing.
- R9: Every result appears exactly one clock after `op_valid`, with `res_fault` the inverse of `res_permit`. A cycle without `op_valid` yields no valid result and no ring change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gw_en | input | 1 | Gate entry write strobe |
| gw_vec | input | 8 | Gate vector to write |
| gw_addr | input | 32 | Handler address to store |
| gw_ring | input | 2 | Target ring to store |
| io_lim_we | input | 1 | I/O threshold write strobe |
| io_lim | input | 2 | New I/O threshold |
| op_valid | input | 1 | An operation is presented |
| op_class | input | 3 | Operation class code |
| op_vec | input | 8 | Vector for a software interrupt |
| res_valid | output | 1 | Result of last cycle's operation |
| res_permit | output | 1 | Operation allowed |
| res_fault | output | 1 | Operation refused |
| cur_ring | output | 2 | Ring now in force |
| res_handler | output | 32 | Handler address from the last taken gate |
| res_saved_ring | output | 2 | Ring pushed or popped by the last gate or return |

## Verification
Privileged classes are tried in ring 0 and in ring 3 to show that the ring alone decides the outcome. Port I/O is tried in ring 3 under thresholds 0, 2 and 3, which places the comparison boundary exactly. Gates with four different target rings are entered in a chain eight deep and then unwound, so that any wrong stack order, lost level or wrong saved ring shows up. A ninth entry and returns on an empty stack probe both limits of the stack.

// File: rtl/ring_guard_pkg.sv
package ring_guard_pkg;

    typedef enum logic [2:0] {
        OPC_PLAIN  = 3'd0,
        OPC_IEN    = 3'd1,
        OPC_IDIS   = 3'd2,
        OPC_PDBASE = 3'd3,
        OPC_PORTIO = 3'd4,
        OPC_SWINT  = 3'd5,
        OPC_IRET   = 3'd6
    } opc_e;

    typedef logic [1:0] ring_t;

endpackage

// File: rtl/ring_gate_table.sv
module ring_gate_table #(
    parameter int NVEC   = 256,
    parameter int ADDR_W = 32,
    localparam int VEC_W = $clog2(NVEC)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [VEC_W-1:0]           wr_vec,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  ring_guard_pkg::ring_t      wr_ring,
    input  logic [VEC_W-1:0]           rd_vec,
    output logic [ADDR_W-1:0]          rd_addr,
    output ring_guard_pkg::ring_t      rd_ring
);
    logic [ADDR_W-1:0]     addr_q [NVEC];
    ring_guard_pkg::ring_t ring_q [NVEC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NVEC; i++) begin
                addr_q[i] <= '0;
                ring_q[i] <= '0;
            end
        end else if (wr_en) begin
            addr_q[wr_vec] <= wr_addr;
            ring_q[wr_vec] <= wr_ring;
        end
    end

    assign rd_addr = addr_q[rd_vec];
    assign rd_ring = ring_q[rd_vec];
endmodule

// File: rtl/ring_ret_stack.sv
module ring_ret_stack #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  logic                  pop,
    input  ring_guard_pkg::ring_t push_ring,
    output ring_guard_pkg::ring_t top_ring,
    output logic                  full,
    output logic                  empty
);
    ring_guard_pkg::ring_t mem_q [DEPTH];
    logic [CNT_W-1:0]      cnt_q;
    logic [IDX_W-1:0]      wr_idx;
    logic [IDX_W-1:0]      rd_idx;

    assign wr_idx   = cnt_q[IDX_W-1:0];
    assign rd_idx   = IDX_W'(wr_idx - IDX_W'(1));
    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign top_ring = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push && !full) begin
            mem_q[wr_idx] <= push_ring;
            cnt_q         <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_q         <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/ring_guard.sv
module ring_guard #(
    parameter int NVEC      = 256,
    parameter int ADDR_W    = 32,
    parameter int STK_DEPTH = 8,
    localparam int VEC_W    = $clog2(NVEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gw_en,
    input  logic [VEC_W-1:0]  gw_vec,
    input  logic [ADDR_W-1:0] gw_addr,
    input  logic [1:0]        gw_ring,
    input  logic              io_lim_we,
    input  logic [1:0]        io_lim,
    input  logic              op_valid,
    input  logic [2:0]        op_class,
    input  logic [VEC_W-1:0]  op_vec,
    output logic              res_valid,
    output logic              res_permit,
    output logic              res_fault,
    output logic [1:0]        cur_ring,
    output logic [ADDR_W-1:0] res_handler,
    output logic [1:0]        res_saved_ring
);
    import ring_guard_pkg::*;

    typedef struct packed {
        ring_t             ring;
        ring_t             io_lim;
        logic              valid;
        logic              permit;
        logic [ADDR_W-1:0] handler;
        ring_t             saved;
    } state_t;

    state_t            s_d, s_q;
    logic              stk_push, stk_pop, stk_full, stk_empty;
    ring_t             stk_top, gate_ring;
    logic [ADDR_W-1:0] gate_addr;

    ring_gate_table #(.NVEC(NVEC), .ADDR_W(ADDR_W)) u_gates (
        .clk(clk), .rst(rst),
        .wr_en(gw_en), .wr_vec(gw_vec), .wr_addr(gw_addr), .wr_ring(gw_ring),
        .rd_vec(op_vec), .rd_addr(gate_addr), .rd_ring(gate_ring)
    );

    ring_ret_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk(clk), .rst(rst),
        .push(stk_push), .pop(stk_pop), .push_ring(s_q.ring),
        .top_ring(stk_top), .full(stk_full), .empty(stk_empty)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        if (io_lim_we) s_d.io_lim = io_lim;
        if (op_valid) begin
            s_d.valid  = 1'b1;
            s_d.permit = 1'b0;
            case (opc_e'(op_class))
                OPC_IEN, OPC_IDIS, OPC_PDBASE: s_d.permit = (s_q.ring == 2'd0);
                OPC_PORTIO:                    s_d.permit = (s_q.ring <= s_q.io_lim);
                OPC_SWINT: begin
                    if (!stk_full) begin
                        s_d.permit  = 1'b1;
                        stk_push    = 1'b1;
                        s_d.ring    = gate_ring;
                        s_d.handler = gate_addr;
                        s_d.saved   = s_q.ring;
                    end
                end
                OPC_IRET: begin
                    if (!stk_empty) begin
                        s_d.permit = 1'b1;
                        stk_pop    = 1'b1;
                        s_d.ring   = stk_top;
                        s_d.saved  = stk_top;
                    end
                end
                default: s_d.permit = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign res_valid      = s_q.valid;
    assign res_permit     = s_q.valid & s_q.permit;
    assign res_fault      = s_q.valid & ~s_q.permit;
    assign cur_ring       = s_q.ring;
    assign res_handler    = s_q.handler;
    assign res_saved_ring = s_q.saved;
endmodule

// File: rtl/ring_guard_chk.sv
module ring_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_class,
    input logic       res_valid,
    input logic       res_permit,
    input logic       res_fault,
    input logic [1:0] cur_ring
);
    import ring_guard_pkg::*;

    logic is_priv;
    assign is_priv = (op_class == OPC_IEN) || (op_class == OPC_IDIS) || (op_class == OPC_PDBASE);

    p_priv_fault_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_priv && cur_ring != 2'd0) |=> (res_fault && $stable(cur_ring)));

    p_io_ring0_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == OPC_PORTIO && cur_ring == 2'd0) |=> res_permit);

    p_plain_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_class == OPC_PLAIN || op_class == 3'd7)) |=> (res_permit && $stable(cur_ring)));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(cur_ring)));

    p_result_r9: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (res_valid && (res_permit != res_fault)));

    p_iret_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == OPC_IRET) |=> (res_fault |-> $stable(cur_ring)));
endmodule

bind ring_guard ring_guard_chk u_chk (.*);

// File: tb/ring_guard_tb.sv
module ring_guard_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        gw_en, io_lim_we, op_valid;
    logic [7:0]  gw_vec, op_vec;
    logic [31:0] gw_addr;
    logic [1:0]  gw_ring, io_lim;
    logic [2:0]  op_class;
    logic        res_valid, res_permit, res_fault;
    logic [1:0]  cur_ring, res_saved_ring;
    logic [31:0] res_handler;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    ring_guard u_dut (
        .clk(clk), .rst(rst), .gw_en(gw_en), .gw_vec(gw_vec), .gw_addr(gw_addr),
        .gw_ring(gw_ring), .io_lim_we(io_lim_we), .io_lim(io_lim),
        .op_valid(op_valid), .op_class(op_class), .op_vec(op_vec),
        .res_valid(res_valid), .res_permit(res_permit), .res_fault(res_fault),
        .cur_ring(cur_ring), .res_handler(res_handler), .res_saved_ring(res_saved_ring)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic write_gate(logic [7:0] v, logic [31:0] a, logic [1:0] r);
        @(negedge clk);
        gw_en = 1'b1; gw_vec = v; gw_addr = a; gw_ring = r;
        @(negedge clk);
        gw_en = 1'b0;
    endtask

    task automatic set_lim(logic [1:0] l);
        @(negedge clk);
        io_lim_we = 1'b1; io_lim = l;
        @(negedge clk);
        io_lim_we = 1'b0;
    endtask

    // drive one op, sample its registered result one clock later
    task automatic do_op(logic [2:0] c, logic [7:0] v);
        @(negedge clk);
        op_valid = 1'b1; op_class = c; op_vec = v;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_res(string req, logic permit, logic [1:0] ring);
        check(req, "valid", {31'b0, res_valid}, 32'd1);
        check(req, "permit", {31'b0, res_permit}, {31'b0, permit});
        check(req, "fault", {31'b0, res_fault}, {31'b0, ~permit});
        check(req, "ring", {30'b0, cur_ring}, {30'b0, ring});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "ring after reset", {30'b0, cur_ring}, 32'd0);
        check("R1", "valid after reset", {31'b0, res_valid}, 32'd0);
        do_op(3'd6, 8'd0);
        expect_res("R7", 1'b0, 2'd0);
        do_op(3'd4, 8'd0);
        expect_res("R1", 1'b1, 2'd0);
        do_op(3'd5, 8'h42);                  // untouched gate
        expect_res("R1", 1'b1, 2'd0);
        check("R1", "blank gate handler", res_handler, 32'd0);
        do_op(3'd6, 8'd0);
        expect_res("R5", 1'b1, 2'd0);
    endtask

    task automatic t_priv_ring0();
        do_op(3'd1, 8'd0); expect_res("R2", 1'b1, 2'd0);
        do_op(3'd2, 8'd0); expect_res("R2", 1'b1, 2'd0);
        do_op(3'd3, 8'd0); expect_res("R2", 1'b1, 2'd0);
        do_op(3'd0, 8'd0); expect_res("R8", 1'b1, 2'd0);
    endtask

    task automatic t_user_ring();
        do_op(3'd5, 8'h21);
        expect_res("R4", 1'b1, 2'd3);
        check("R4", "handler", res_handler, 32'h0000_0abc);
        check("R4", "saved", {30'b0, res_saved_ring}, 32'd0);
        do_op(3'd1, 8'd0); expect_res("R2", 1'b0, 2'd3);
        do_op(3'd3, 8'd0); expect_res("R2", 1'b0, 2'd3);
        do_op(3'd4, 8'd0); expect_res("R3", 1'b0, 2'd3);
        set_lim(2'd2);
        do_op(3'd4, 8'd0); expect_res("R3", 1'b0, 2'd3);
        set_lim(2'd3);
        do_op(3'd4, 8'd0); expect_res("R3", 1'b1, 2'd3);
        do_op(3'd7, 8'd0); expect_res("R8", 1'b1, 2'd3);
        @(negedge clk);
        check("R9", "idle valid", {31'b0, res_valid}, 32'd0);
        check("R9", "idle ring", {30'b0, cur_ring}, 32'd3);
        do_op(3'd5, 8'h80);
        expect_res("R4", 1'b1, 2'd0);
        check("R4", "handler 80", res_handler, 32'h0000_1234);
        check("R4", "saved 3", {30'b0, res_saved_ring}, 32'd3);
        do_op(3'd6, 8'd0);
        expect_res("R5", 1'b1, 2'd3);
        check("R5", "popped", {30'b0, res_saved_ring}, 32'd3);
        do_op(3'd6, 8'd0);
        expect_res("R5", 1'b1, 2'd0);
        do_op(3'd6, 8'd0);
        expect_res("R7", 1'b0, 2'd0);
    endtask

    task automatic t_nesting();
        logic [7:0] vecs [4] = '{8'h00, 8'hff, 8'h21, 8'h80};
        logic [1:0] rings [4] = '{2'd1, 2'd2, 2'd3, 2'd0};
        logic [1:0] model [8];
        logic [1:0] r = 2'd0;
        for (int i = 0; i < 8; i++) begin
            model[i] = r;
            do_op(3'd5, vecs[i % 4]);
            r = rings[i % 4];
            expect_res("R6", 1'b1, r);
            check("R4", "nested saved", {30'b0, res_saved_ring}, {30'b0, model[i]});
        end
        do_op(3'd5, 8'hff);
        expect_res("R6", 1'b0, r);
        for (int i = 7; i >= 0; i--) begin
            do_op(3'd6, 8'd0);
            expect_res("R5", 1'b1, model[i]);
        end
        do_op(3'd6, 8'd0);
        expect_res("R7", 1'b0, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; gw_en = 1'b0; io_lim_we = 1'b0; op_valid = 1'b0;
        gw_vec = '0; gw_addr = '0; gw_ring = '0; io_lim = '0; op_class = '0; op_vec = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_priv_ring0();
        write_gate(8'h80, 32'h0000_1234, 2'd0);
        write_gate(8'h21, 32'h0000_0abc, 2'd3);
        write_gate(8'hff, 32'h0000_beef, 2'd2);
        write_gate(8'h00, 32'h0000_0010, 2'd1);
        t_user_ring();
        t_nesting();
        done = 1'b1;
        report();
        $finish;
    end
endmodule